// File: doc/BRIEF.md
# Chip-Select-Gated Periodic Sample Register

This block sits between a free-running data converter and a serial slave engine. It keeps the newest converted values: two 11-bit acceleration words and one temperature word. The converter presents each result with a one-cycle valid strobe, and the block captures it into a staging register. A prescaler built on the system clock produces a periodic load tick, 150 clocks by default (150 µs at 1 MHz). On each tick the staged sample is copied, all fields at once, into the parallel output words that the serial engine reads.

The copy is blocked while the active-low chip select is asserted, so a serial read in progress always sees constant words. A tick that arrives while the chip select is low is lost, not held over. The first load after release therefore happens at the next tick. A host that wants fresh data keeps chip select high for at least one full tick period before it starts a read. A `fresh` flag goes high on every load and drops when chip select falls. The chip select is brought into the clock domain through a flop synchronizer before it gates anything.

Top module: `sel_gated_sample_reg`

## Requirements
- R1: While `rst` is high and on the first clock after it, all three output words and `fresh` read zero, whatever the other inputs do.
- R2: The load tick repeats every TICK_DIV clocks, counted from reset release. With chip select high throughout, a staged value appears on the outputs one clock after the tick edge.
- R3: The staging register takes `conv_z`, `conv_y` and `conv_temp` only in a cycle with `conv_valid` high. Input changes without the strobe never reach the outputs.
- R4: While the synchronized chip select is low, `z_word`, `y_word` and `temp_word` do not change, across any number of ticks.
- R5: A tick seen while the synchronized chip select is low is dropped. After release, the next load happens at the first tick with chip select high, not at release.
- R6: `fresh` goes to 1 on each load. It goes to 0 one clock after the synchronized chip select falls, and that clear wins over a load.
- R7: The temperature word follows exactly the same staging, gating and load rules as the acceleration words.
- R8: `cs_n` passes through SYNC_STAGES flops (default 2) before it gates loads or clears `fresh`. A fall at the pins therefore clears `fresh` three clocks later by default.
- R9: The Z, Y and temperature words update together at the same clock edge, all from one staged sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low, asynchronous to clk |
| conv_valid | input | 1 | One-cycle strobe marking a new converter result |
| conv_z | input | ACC_W | Z acceleration from the converter |
| conv_y | input | ACC_W | Y acceleration from the converter |
| conv_temp | input | TEMP_W | Temperature from the converter |
| z_word | output | ACC_W | Held Z acceleration for the serial engine |
| y_word | output | ACC_W | Held Y acceleration for the serial engine |
| temp_word | output | TEMP_W | Held temperature for the serial engine |
| fresh | output | 1 | Set on load, cleared by chip-select fall |

## Verification
A prescaler stuck or off by one shows up as a missing or early load. With chip select high it is visible within one tick period, and across a release it shows as `fresh` rising on the wrong clock. Broken gating shows as an output word changing while chip select is low, at the first tick inside the low window. The bench stages new data during that window so such a change cannot go unseen. A synchronizer of the wrong depth moves the clear of `fresh` by whole clocks, and the bench checks that clear on both neighbouring clocks.

// File: rtl/smpreg_pkg.sv
package smpreg_pkg;
  localparam int unsigned DEF_ACC_W    = 11;
  localparam int unsigned DEF_TEMP_W   = 8;
  localparam int unsigned DEF_TICK_DIV = 150;
  localparam int unsigned DEF_SYNC     = 2;

  // counter width able to hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/cs_sync.sv
module cs_sync #(
  parameter int unsigned STAGES    = 2,
  parameter bit          RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  generate
    if (STAGES < 2) begin : g_single
      logic ff_q;
      always_ff @(posedge clk) begin
        if (rst) ff_q <= RESET_VAL;
        else     ff_q <= async_in;
      end
      assign sync_out = ff_q;
    end else begin : g_chain
      logic [STAGES-1:0] pipe_q;
      always_ff @(posedge clk) begin
        if (rst) pipe_q <= {STAGES{RESET_VAL}};
        else     pipe_q <= {pipe_q[STAGES-2:0], async_in};
      end
      assign sync_out = pipe_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/tick_gen.sv
module tick_gen import smpreg_pkg::*; #(
  parameter int unsigned DIV = DEF_TICK_DIV
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CNT_W = cnt_width(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/word_reg.sv
module word_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cap_en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/sel_gated_sample_reg.sv
module sel_gated_sample_reg import smpreg_pkg::*; #(
  parameter int unsigned ACC_W       = DEF_ACC_W,
  parameter int unsigned TEMP_W      = DEF_TEMP_W,
  parameter int unsigned TICK_DIV    = DEF_TICK_DIV,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              conv_valid,
  input  logic [ACC_W-1:0]  conv_z,
  input  logic [ACC_W-1:0]  conv_y,
  input  logic [TEMP_W-1:0] conv_temp,
  output logic [ACC_W-1:0]  z_word,
  output logic [ACC_W-1:0]  y_word,
  output logic [TEMP_W-1:0] temp_word,
  output logic              fresh
);
  localparam int unsigned PACK_W = 2 * ACC_W + TEMP_W;

  logic              cs_q;
  logic              cs_prev_q;
  logic              cs_fall;
  logic              tick;
  logic              load_en;
  logic [PACK_W-1:0] stage_q;
  logic [PACK_W-1:0] hold_q;

  // chip select into the clock domain; idle (deselected) out of reset
  cs_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .async_in(cs_n), .sync_out(cs_q)
  );

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  // newest converter result, taken only on its strobe
  word_reg #(.W(PACK_W)) u_stage (
    .clk(clk), .rst(rst), .cap_en(conv_valid),
    .d({conv_z, conv_y, conv_temp}), .q(stage_q)
  );

  // a tick with the bus selected is simply lost
  assign load_en = tick & cs_q;

  word_reg #(.W(PACK_W)) u_hold (
    .clk(clk), .rst(rst), .cap_en(load_en), .d(stage_q), .q(hold_q)
  );

  assign cs_fall = cs_prev_q & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_prev_q <= 1'b1;
      fresh     <= 1'b0;
    end else begin
      cs_prev_q <= cs_q;
      if (cs_fall)      fresh <= 1'b0;
      else if (load_en) fresh <= 1'b1;
    end
  end

  assign z_word    = hold_q[PACK_W-1 -: ACC_W];
  assign y_word    = hold_q[TEMP_W +: ACC_W];
  assign temp_word = hold_q[TEMP_W-1:0];
endmodule

// File: rtl/sel_gated_sample_reg_chk.sv
module sel_gated_sample_reg_chk #(
  parameter int unsigned ACC_W    = 11,
  parameter int unsigned TEMP_W   = 8,
  parameter int unsigned TICK_DIV = 150
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          cs_s,
  input logic                          tick,
  input logic                          conv_valid,
  input logic [2*ACC_W+TEMP_W-1:0]     stage,
  input logic [ACC_W-1:0]              z_word,
  input logic [ACC_W-1:0]              y_word,
  input logic [TEMP_W-1:0]             temp_word,
  input logic                          fresh
);
  localparam int unsigned GAP_W = $clog2(TICK_DIV + 1) + 1;

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (rst)       gap_q <= '0;
    else if (tick) gap_q <= '0;
    else           gap_q <= gap_q + 1'b1;
  end

  // R2: ticks are exactly TICK_DIV clocks apart
  assert_tick_period_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == GAP_W'(TICK_DIV - 1)));

  // R4, R7, R9: outputs only move after a tick seen with chip select high
  assert_hold_while_low_R4: assert property (@(posedge clk) disable iff (rst)
    (!$stable({z_word, y_word, temp_word}) && !$past(rst)) |->
      ($past(cs_s) && $past(tick)));

  // R3: staging moves only on a converter strobe
  assert_stage_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!$stable(stage) && !$past(rst)) |-> $past(conv_valid));

  // R6: fresh rises only through a permitted load
  assert_fresh_set_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(fresh) && !$past(rst)) |-> ($past(tick) && $past(cs_s)));

  // R6: a chip-select fall clears fresh on the next clock
  assert_fresh_clear_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_s) |=> !fresh);
endmodule

bind sel_gated_sample_reg sel_gated_sample_reg_chk #(
  .ACC_W(ACC_W), .TEMP_W(TEMP_W), .TICK_DIV(TICK_DIV)
) chk_i (
  .clk(clk), .rst(rst), .cs_s(cs_q), .tick(tick), .conv_valid(conv_valid),
  .stage(stage_q), .z_word(z_word), .y_word(y_word),
  .temp_word(temp_word), .fresh(fresh)
);

// File: tb/sel_gated_sample_reg_tb_top.sv
module sel_gated_sample_reg_tb_top;
  localparam int unsigned ACC_W  = 11;
  localparam int unsigned TEMP_W = 8;
  localparam int unsigned DIV    = 8;
  localparam int unsigned HOLD   = 24;

  logic              clk = 1'b0;
  logic              rst;
  logic              cs_n;
  logic              conv_valid;
  logic [ACC_W-1:0]  conv_z, conv_y;
  logic [TEMP_W-1:0] conv_temp;
  logic [ACC_W-1:0]  z_word, y_word;
  logic [TEMP_W-1:0] temp_word;
  logic              fresh;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sel_gated_sample_reg #(
    .ACC_W(ACC_W), .TEMP_W(TEMP_W), .TICK_DIV(DIV), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .conv_valid(conv_valid),
    .conv_z(conv_z), .conv_y(conv_y), .conv_temp(conv_temp),
    .z_word(z_word), .y_word(y_word), .temp_word(temp_word), .fresh(fresh)
  );

  typedef struct packed {
    logic              cs_n;
    logic              valid;
    logic [ACC_W-1:0]  z;
    logic [ACC_W-1:0]  y;
    logic [TEMP_W-1:0] t;
    logic [ACC_W-1:0]  ez;
    logic [ACC_W-1:0]  ey;
    logic [TEMP_W-1:0] et;
    logic              ef;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b1, 11'h155, 11'h2AA, 8'hC3, 11'h155, 11'h2AA, 8'hC3, 1'b1},
    '{1'b0, 1'b1, 11'h7FF, 11'h001, 8'hFF, 11'h155, 11'h2AA, 8'hC3, 1'b0},
    '{1'b1, 1'b0, 11'h0AA, 11'h0AA, 8'hAA, 11'h7FF, 11'h001, 8'hFF, 1'b1},
    '{1'b1, 1'b1, 11'h400, 11'h3FF, 8'h80, 11'h400, 11'h3FF, 8'h80, 1'b1},
    '{1'b0, 1'b1, 11'h000, 11'h7FF, 8'h23, 11'h400, 11'h3FF, 8'h80, 1'b0},
    '{1'b1, 1'b0, 11'h321, 11'h123, 8'h5A, 11'h000, 11'h7FF, 8'h23, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_words(input string req, input logic [ACC_W-1:0] ez,
                           input logic [ACC_W-1:0] ey, input logic [TEMP_W-1:0] et);
    chk({req, " z"}, 32'(z_word), 32'(ez));
    chk({req, " y"}, 32'(y_word), 32'(ey));
    chk({req, " temp R7"}, 32'(temp_word), 32'(et));
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit seen;
    rst = 1'b1; cs_n = 1'b1; conv_valid = 1'b1;
    conv_z = 11'h7AB; conv_y = 11'h3CD; conv_temp = 8'hEE;
    repeat (3) @(negedge clk);
    // R1: reset holds everything at zero despite input activity
    chk_words("R1 reset", '0, '0, '0);
    chk("R1 reset fresh", 32'(fresh), 32'd0);
    conv_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk_words("R1 after release", '0, '0, '0);

    // table walk: R2 R3 R4 R6 R7 R9
    for (int i = 0; i < NVEC; i++) begin
      cs_n = VEC[i].cs_n;
      repeat (4) @(negedge clk);
      conv_z = VEC[i].z; conv_y = VEC[i].y; conv_temp = VEC[i].t;
      conv_valid = VEC[i].valid;
      @(negedge clk);
      conv_valid = 1'b0;
      repeat (HOLD) @(negedge clk);
      chk_words($sformatf("R2 R3 R4 R9 vector %0d", i), VEC[i].ez, VEC[i].ey, VEC[i].et);
      chk($sformatf("R6 vector %0d fresh", i), 32'(fresh), 32'(VEC[i].ef));
    end

    // directed: dropped tick, synchronizer depth (R5 R6 R8)
    cs_n = 1'b0;
    repeat (10) @(negedge clk);
    cs_n = 1'b1;
    seen = 1'b0;
    for (int w = 0; w < 20 && !seen; w++) begin
      @(negedge clk);
      if (fresh) seen = 1'b1;
    end
    chk("R2 load after release", 32'(seen), 32'd1);
    cs_n = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      case (k)
        2: chk("R8 fresh still set inside sync delay", 32'(fresh), 32'd1);
        3: chk("R6 fresh cleared after chip-select fall", 32'(fresh), 32'd0);
        4: begin
          conv_z = 11'h5A5; conv_y = 11'h25A; conv_temp = 8'h3C; conv_valid = 1'b1;
        end
        5: conv_valid = 1'b0;
        9: chk_words("R4 tick while low ignored", 11'h000, 11'h7FF, 8'h23);
        10: cs_n = 1'b1;
        15: begin
          chk("R5 no load at release", 32'(fresh), 32'd0);
          chk_words("R5 words before next tick", 11'h000, 11'h7FF, 8'h23);
        end
        16: begin
          chk("R5 load at first tick after release", 32'(fresh), 32'd1);
          chk_words("R9 words together", 11'h5A5, 11'h25A, 8'h3C);
        end
        default: ;
      endcase
    end

    // R1: reset in the middle of operation
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk_words("R1 mid-run reset", '0, '0, '0);
    chk("R1 mid-run fresh", 32'(fresh), 32'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule